// File: doc/BRIEF.md
# Legacy Region Attribute Decoder

This block steers every memory access that falls in the legacy low-megabyte area, or in one of two fixed memory holes, either to DRAM or out to the I/O bus. Each access arrives as an address plus a read/write flag, and the answer comes back one clock later as a pair of flags: "DRAM selected" or "forward to bus". Exactly one of the two is raised for every request. When no request is made, both stay low.

The expansion area 0xC0000–0xEFFFF is cut into twelve 16 KB segments. The 64 KB firmware area 0xF0000–0xFFFFF is treated as one segment. Each segment owns a 2-bit attribute field. Because the field has one bit per direction, a segment can be opened to DRAM for reads only, for writes only, for both, or for neither. This is what shadowing firmware into DRAM needs.

The fields sit two to a byte in a small bank of attribute bytes, loaded through a plain indexed write port. The same index reads a byte back. A 2-bit hole-mode input can carve one of two fixed windows out of DRAM. Addresses inside the enabled window always go to the bus.

Top module: `lrad_top`

## Requirements
- R1: An attribute field uses bit 0 for reads and bit 1 for writes. A set bit sends an access of that direction to DRAM, and a clear bit sends it to the bus. So 00 means all accesses go to the bus, 01 means reads only go to DRAM, 10 means writes only go to DRAM, and 11 means all accesses go to DRAM.
- R2: An address A in 0xC0000–0xEFFFF belongs to segment k = (A − 0xC0000) / 16384, where k runs from 0 to 11. The field for segment k is in attribute byte 1 + k/2. It uses bits [1:0] when k is even and bits [5:4] when k is odd.
- R3: Addresses 0xF0000–0xFFFFF form one segment, controlled by bits [5:4] of attribute byte 0.
- R4: The hole mode works as follows. 00 means no hole. 01 makes 0x80000–0x9FFFF a hole. 10 makes 0xF00000–0xFFFFFF a hole. 11 means no hole. Any access inside the enabled hole goes to the bus, for both reads and writes.
- R5: The following routing applies outside an enabled hole. Addresses below 0xA0000 go to DRAM. Addresses at or above 0x100000 go to DRAM. Addresses 0xA0000–0xBFFFF always go to the bus.
- R6: Only bits 0x33 of attribute bytes 1–6 can be written, and only bits 0x30 of byte 0. All other bits ignore writes and read back as zero. Indices 7 and above hold nothing: they read zero, and writes to them change no routing.
- R7: After reset, every attribute byte reads zero, so every attribute-controlled segment routes to the bus. The response flags are low in the first cycle after reset.
- R8: A request presented in cycle N produces its response flags in cycle N+1. When a response is valid, exactly one of the DRAM and bus flags is high. Without a request, all three response outputs are low.
- R9: A write to an attribute byte applies to requests from the following cycle onward. A request made in the same cycle as the write still sees the old value. Read data reflects the index presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the attribute byte at cfg_idx |
| cfg_idx | input | IDX_W (3) | Attribute byte index for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the byte at cfg_idx, reserved bits zero |
| hole_mode | input | 2 | Fixed hole selection |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| req_addr | input | ADDR_W (32) | Access byte address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_dram | output | 1 | Access is claimed by DRAM |
| rsp_bus | output | 1 | Access is forwarded to the I/O bus |

## Verification
The assertions assume that `hole_mode` and the attribute bytes are stable across a request cycle only through the ordinary register timing. They also assume that `cfg_idx` is driven to a known value whenever `cfg_wr_en` is high. The bench keeps to this by changing all inputs on the falling edge and never leaving X on the request or write strobes. It sweeps the first and last words of every segment in both directions under several attribute patterns. It then walks the edges of both holes and of the video window under all four hole modes. A byte shadow model inside the bench applies the write masks.

// File: rtl/lrad_pkg.sv
// Package: shared constants and route classes for the legacy region decoder.
// Assumes addresses are at least 25 bits wide so the 16 MB boundary is representable.
package lrad_pkg;

    typedef enum logic [1:0] {
        CLS_DRAM = 2'd0,
        CLS_BUS  = 2'd1,
        CLS_ATTR = 2'd2
    } route_cls_e;

    localparam logic [31:0] LOW_HOLE_BASE  = 32'h0008_0000;
    localparam logic [31:0] VIDEO_BASE     = 32'h000A_0000;
    localparam logic [31:0] EXT_BASE       = 32'h000C_0000;
    localparam logic [31:0] FW_BASE        = 32'h000F_0000;
    localparam logic [31:0] ONE_MEG        = 32'h0010_0000;
    localparam logic [31:0] HIGH_HOLE_BASE = 32'h00F0_0000;
    localparam logic [31:0] SIXTEEN_MEG    = 32'h0100_0000;

    localparam logic [1:0] HOLE_LOW_MODE  = 2'b01;
    localparam logic [1:0] HOLE_HIGH_MODE = 2'b10;

    localparam logic [7:0] FW_BYTE_MASK  = 8'h30;
    localparam logic [7:0] EXT_BYTE_MASK = 8'h33;

endpackage

// File: rtl/lrad_attr_regs.sv
// Module: attribute byte bank.
// Holds NUM_BYTES bytes. Only the two 2-bit field positions are writable,
// and byte 0 has only its upper field. Exposes every field as a flat vector
// and gives combinational read-back at the presented index.
// Assumes cfg_idx is known whenever wr_en is high.
module lrad_attr_regs #(
    parameter int NUM_BYTES  = 7,
    parameter int IDX_W      = 3,
    parameter int NUM_FIELDS = 2 * NUM_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    output logic [2*NUM_FIELDS-1:0] fields
);
    import lrad_pkg::*;

    logic [7:0] regs_q [NUM_BYTES];

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        localparam logic [7:0] MASK = (b == 0) ? FW_BYTE_MASK : EXT_BYTE_MASK;

        // Purpose: load the masked write data, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[b] <= 8'h00;
            else if (wr_en && idx == IDX_W'(b))
                regs_q[b] <= wdata & MASK;
        end

        assign fields[4*b +: 2]     = regs_q[b][1:0];
        assign fields[4*b + 2 +: 2] = regs_q[b][5:4];

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && idx == IDX_W'(b)) |=> (regs_q[b] == ($past(wdata) & MASK))); // R6

        AST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && idx == IDX_W'(b)) |=> $stable(regs_q[b])); // R9
    end

    // Purpose: return the addressed byte, zero for indices past the bank.
    always_comb begin
        rdata = 8'h00;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (idx == IDX_W'(b))
                rdata = regs_q[b];
        end
    end

endmodule

// File: rtl/lrad_classify.sv
// Module: address classifier.
// Sorts an address into plain DRAM, forced bus, or an attribute-controlled
// segment, and gives the field number of that segment. Field numbering:
// firmware area = 1, expansion segment k = k + 2, field 0 is unused.
// Assumes ADDR_W >= 25 and SEG_SHIFT gives 16 KB segments.
module lrad_classify #(
    parameter int ADDR_W    = 32,
    parameter int SEG_SHIFT = 14,
    parameter int FLD_W     = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          hole_mode,
    output lrad_pkg::route_cls_e cls,
    output logic [FLD_W-1:0]    fld_idx,
    output logic                hole_hit
);
    import lrad_pkg::*;

    logic in_low_hole, in_high_hole;
    logic [ADDR_W-1:0] ext_off;

    assign in_low_hole  = (addr >= ADDR_W'(LOW_HOLE_BASE))  && (addr < ADDR_W'(VIDEO_BASE));
    assign in_high_hole = (addr >= ADDR_W'(HIGH_HOLE_BASE)) && (addr < ADDR_W'(SIXTEEN_MEG));
    assign ext_off      = addr - ADDR_W'(EXT_BASE);

    // Purpose: detect an access that falls in the currently enabled hole.
    always_comb begin
        hole_hit = 1'b0;
        if (hole_mode == HOLE_LOW_MODE)
            hole_hit = in_low_hole;
        else if (hole_mode == HOLE_HIGH_MODE)
            hole_hit = in_high_hole;
    end

    // Purpose: choose the route class and the controlling field.
    always_comb begin
        cls     = CLS_DRAM;
        fld_idx = '0;
        if (hole_hit) begin
            cls = CLS_BUS;
        end else if (addr < ADDR_W'(VIDEO_BASE)) begin
            cls = CLS_DRAM;
        end else if (addr < ADDR_W'(EXT_BASE)) begin
            cls = CLS_BUS;
        end else if (addr < ADDR_W'(FW_BASE)) begin
            cls     = CLS_ATTR;
            fld_idx = FLD_W'(ext_off >> SEG_SHIFT) + FLD_W'(2);
        end else if (addr < ADDR_W'(ONE_MEG)) begin
            cls     = CLS_ATTR;
            fld_idx = FLD_W'(1);
        end else begin
            cls = CLS_DRAM;
        end
    end

endmodule

// File: rtl/lrad_route_pick.sv
// Module: field select and direction decode.
// Picks the controlling attribute field and turns it, with the access
// direction, into a DRAM-or-bus decision.
// Assumes fld_idx is meaningful only when cls is CLS_ATTR.
module lrad_route_pick #(
    parameter int NUM_FIELDS = 14,
    parameter int FLD_W      = 4
) (
    input  lrad_pkg::route_cls_e    cls,
    input  logic [FLD_W-1:0]        fld_idx,
    input  logic                    is_write,
    input  logic [2*NUM_FIELDS-1:0] fields,
    output logic [1:0]              field,
    output logic                    to_dram
);
    import lrad_pkg::*;

    // Purpose: select the addressed 2-bit field, zero when out of range.
    always_comb begin
        field = 2'b00;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (fld_idx == FLD_W'(f))
                field = fields[2*f +: 2];
        end
    end

    // Purpose: apply class and direction to reach the final route.
    always_comb begin
        case (cls)
            CLS_DRAM: to_dram = 1'b1;
            CLS_ATTR: to_dram = is_write ? field[1] : field[0];
            default:  to_dram = 1'b0;
        endcase
    end

endmodule

// File: rtl/lrad_top.sv
// Module: legacy region attribute decoder, top level.
// Classifies each request, looks up its attribute field, and registers
// a one-hot DRAM/bus response one cycle later.
// Assumes requests and configuration inputs change away from the clock edge.
module lrad_top #(
    parameter int ADDR_W    = 32,
    parameter int NUM_BYTES = 7,
    parameter int SEG_SHIFT = 14,
    localparam int IDX_W      = $clog2(NUM_BYTES + 1),
    localparam int NUM_FIELDS = 2 * NUM_BYTES,
    localparam int FLD_W      = $clog2(NUM_FIELDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [1:0]        hole_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_dram,
    output logic              rsp_bus
);
    import lrad_pkg::*;

    logic [2*NUM_FIELDS-1:0] fields;
    route_cls_e              cls;
    logic [FLD_W-1:0]        fld_idx;
    logic                    hole_hit;
    logic [1:0]              field;
    logic                    to_dram;

    lrad_attr_regs #(
        .NUM_BYTES (NUM_BYTES),
        .IDX_W     (IDX_W),
        .NUM_FIELDS(NUM_FIELDS)
    ) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .fields(fields)
    );

    lrad_classify #(
        .ADDR_W   (ADDR_W),
        .SEG_SHIFT(SEG_SHIFT),
        .FLD_W    (FLD_W)
    ) classify_i (
        .addr     (req_addr),
        .hole_mode(hole_mode),
        .cls      (cls),
        .fld_idx  (fld_idx),
        .hole_hit (hole_hit)
    );

    lrad_route_pick #(
        .NUM_FIELDS(NUM_FIELDS),
        .FLD_W     (FLD_W)
    ) pick_i (
        .cls     (cls),
        .fld_idx (fld_idx),
        .is_write(req_write),
        .fields  (fields),
        .field   (field),
        .to_dram (to_dram)
    );

    // Purpose: register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_dram  <= 1'b0;
            rsp_bus   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_dram  <= req_valid && to_dram;
            rsp_bus   <= req_valid && !to_dram;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && !rsp_dram && !rsp_bus); // R7

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_dram, rsp_bus}) == 1)); // R8

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_dram && !rsp_bus); // R8

    AST_HOLE_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hole_hit) |=> rsp_bus); // R4

    AST_PLAIN_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls == CLS_DRAM) |=> rsp_dram); // R5

    AST_FIELD_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls == CLS_ATTR && field == 2'b00) |=> rsp_bus); // R1

    AST_FIELD_ON_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls == CLS_ATTR && field == 2'b11) |=> rsp_dram); // R1

endmodule

// File: tb/lrad_top_tb_top.sv
`timescale 1ns/1ps
module lrad_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [1:0]  hole_mode = 2'b00;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic        rsp_valid, rsp_dram, rsp_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] shadow [8];

    always #2.5 clk = ~clk;

    lrad_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .hole_mode(hole_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_dram(rsp_dram), .rsp_bus(rsp_bus)
    );

    // Expected route from the requirements: 1 = DRAM, 0 = bus.
    function automatic bit model(input logic [31:0] a, input bit wr, input logic [1:0] hm);
        logic [1:0] f;
        int k;
        if (hm == 2'b01 && a >= 32'h80000 && a < 32'hA0000) return 0;
        if (hm == 2'b10 && a >= 32'hF00000 && a < 32'h1000000) return 0;
        if (a < 32'hA0000) return 1;
        if (a < 32'hC0000) return 0;
        if (a < 32'hF0000) begin
            k = int'((a - 32'hC0000) / 32'd16384);
            f = (k % 2 == 1) ? shadow[1 + k/2][5:4] : shadow[1 + k/2][1:0];
        end else if (a < 32'h100000) begin
            f = shadow[0][5:4];
        end else begin
            return 1;
        end
        return wr ? f[1] : f[0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int i, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = 3'(i); cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (i < 7) shadow[i] = d & ((i == 0) ? 8'h30 : 8'h33);
    endtask

    task automatic access(input logic [31:0] a, input bit wr, input string tag);
        bit e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        e = model(a, wr, hole_mode);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && rsp_dram == e && rsp_bus == !e, tag,
              {29'd0, rsp_valid, rsp_dram, rsp_bus}, {29'd0, 1'b1, e, !e});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        check(!rsp_valid && !rsp_dram && !rsp_bus, "R7", {rsp_valid, rsp_dram, rsp_bus}, 0);
        for (int i = 0; i < 8; i++) begin
            cfg_idx = 3'(i); #0.1;
            check(cfg_rdata == 8'h00, "R7", cfg_rdata, 0);
        end
        access(32'hC0000, 0, "R7");
        access(32'hF0000, 1, "R7");

        // Reserved bits and empty indices.
        for (int i = 0; i < 8; i++) cfg_write(i, 8'hFF);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); cfg_idx = 3'(i); #0.1;
            check(cfg_rdata == ((i == 0) ? 8'h30 : (i == 7) ? 8'h00 : 8'h33), "R6",
                  cfg_rdata, (i == 0) ? 8'h30 : (i == 7) ? 8'h00 : 8'h33);
        end

        // Attribute sweeps under several patterns.
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < 7; i++) cfg_write(i, 8'((p * 37 + i * 91) ^ 8'h5A));
            for (int k = 0; k < 12; k++) begin
                for (int w = 0; w < 2; w++) begin
                    access(32'hC0000 + 32'(k) * 32'd16384, w[0], "R2");
                    access(32'hC0000 + 32'(k) * 32'd16384 + 32'h3FFC, w[0], "R1");
                end
            end
            for (int w = 0; w < 2; w++) begin
                access(32'hF0000, w[0], "R3");
                access(32'hFFFFC, w[0], "R3");
            end
        end

        // Holes and fixed windows under every mode.
        for (int i = 0; i < 7; i++) cfg_write(i, 8'hFF);
        for (int m = 0; m < 4; m++) begin
            @(negedge clk); hole_mode = 2'(m);
            for (int w = 0; w < 2; w++) begin
                access(32'h7FFFC, w[0], "R5");
                access(32'h80000, w[0], "R4");
                access(32'h9FFFC, w[0], "R4");
                access(32'hA0000, w[0], "R5");
                access(32'hBFFFC, w[0], "R5");
                access(32'h100000, w[0], "R5");
                access(32'hEFFFFC, w[0], "R5");
                access(32'hF00000, w[0], "R4");
                access(32'hFFFFFC, w[0], "R4");
                access(32'h1000000, w[0], "R5");
            end
        end
        hole_mode = 2'b00;

        // Idle cycle: no response.
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        check(!rsp_valid && !rsp_dram && !rsp_bus, "R8", {rsp_valid, rsp_dram, rsp_bus}, 0);

        // Write timing: same-cycle request sees the old field.
        cfg_write(1, 8'h00);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = 3'd1; cfg_wdata = 8'h03;
        req_valid = 1'b1; req_addr = 32'hC0000; req_write = 1'b0;
        @(negedge clk);
        cfg_wr_en = 1'b0; req_valid = 1'b0; shadow[1] = 8'h03;
        check(rsp_valid && !rsp_dram && rsp_bus, "R9", {rsp_valid, rsp_dram, rsp_bus}, 3'b101);
        access(32'hC0000, 0, "R9");

        // Index 7 write changes no routing.
        cfg_write(0, 8'h00);
        cfg_write(7, 8'hFF);
        access(32'hF0000, 0, "R6");
        access(32'hF0000, 1, "R6");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule